// File: doc/BRIEF.md
# Laser Safety Fault Shutdown Controller

This block guards the optical output of a two-transmitter module. For each channel it receives synchronous single-bit quick-trip flags from the comparators (transmit power too high, transmit power too low, bias current too high, plus an extended high-power trip) and gates each one with its own mask bit. Any unmasked trip drives one shared fault line, modelled as an open-drain pull-down enable, and shuts down the driver of the channel that tripped.

A channel is disabled by its pin or by its software bit. Either one shuts the driver down at once and clears that channel's fault. When the disable is released, the driver stays off for a recovery window of `TICK_DIV * RESET_TICKS` clock cycles, and trips are ignored during that window. By default the window is 130 ms at 125 MHz. One configuration bit chooses how the fault line behaves: it either follows the live trips or holds once set. A small status group reports the pin levels, the software bits and the state of the fault line.

Top module: `lsf_shutdown_ctrl`

## Requirements
- R1: Each of the three main trips of a channel (power high, power low, bias high) counts as a fault only while its own mask bit is 1. A flag whose mask bit is 0 leaves `fault_drive` at 0 and `shutdown` at 0.
- R2: The extended high-power flag of a channel counts as a fault only while that channel's `hx_enable` bit is 1.
- R3: When `latch_mode` is 0, a channel in normal operation drives its fault from the trips sampled on the previous rising edge. The fault appears one cycle after an unmasked trip and clears one cycle after the trip goes away.
- R4: When `latch_mode` is 1, a channel fault stays set after its trip goes away. Only a disable of that same channel clears it. A fault held on the other channel keeps `fault_drive` at 1.
- R5: A channel's disable is its `txdis_pin` bit OR its `sw_txdis` bit. While the disable is 1, that channel's `shutdown` bit is 1 in the same cycle, with no clock edge needed.
- R6: The first rising edge that samples a channel's disable at 1 clears that channel's fault. If a trip arrives in the same cycle, the clear still wins.
- R7: After a disable is released, `shutdown` stays 1 through the first `TICK_DIV*RESET_TICKS` rising edges that sample the disable at 0. Trips are ignored during that time. On the next edge, normal operation resumes.
- R8: `fault_drive` is the OR of the two channel faults. Bit i of `shutdown` is 1 while channel i holds a fault.
- R9: `sts_txdis_pin` reports the pin levels, `sts_sw_txdis` reports the software bits, and `sts_fault` reports the current value of `fault_drive`.
- R10: While `rst` is 1, `fault_drive` is 0, every `shutdown` bit is 1 and every fault is cleared. After `rst` falls, `shutdown` stays 1 for `TICK_DIV*RESET_TICKS` rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qt_pwr_hi | input | NCH | Transmit power high trip, one bit per channel |
| qt_pwr_lo | input | NCH | Transmit power low trip |
| qt_bias_hi | input | NCH | Bias current high trip |
| qt_pwr_hx | input | NCH | Extended high-power trip |
| mask_pwr_hi | input | NCH | Enable for the power-high trip |
| mask_pwr_lo | input | NCH | Enable for the power-low trip |
| mask_bias_hi | input | NCH | Enable for the bias-high trip |
| hx_enable | input | NCH | Enable for the extended high-power trip |
| txdis_pin | input | NCH | Transmit-disable pin levels |
| sw_txdis | input | NCH | Software transmit-disable bits |
| latch_mode | input | 1 | 1 = fault held once set, 0 = fault follows the trips |
| fault_drive | output | 1 | 1 = pull the shared fault line low (fault asserted) |
| shutdown | output | NCH | Driver shutdown, one bit per channel |
| sts_txdis_pin | output | NCH | Status: pin levels |
| sts_sw_txdis | output | NCH | Status: software disable bits |
| sts_fault | output | 1 | Status: current state of the fault line |

## Verification
Two events can land on the same rising edge: a channel's disable being asserted, and an unmasked trip that would set that channel's fault. The bench raises an enabled power-high flag and the disable pin of the same channel at one falling edge, with latching on. It then requires the fault line to stay released and the channel to stay shut down. A second collision happens at the end of the recovery window. There, a trip held through the whole window must not be seen, and the bench drops it on the last falling edge before normal operation resumes, so the channel must release with no fault.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

    // Per-channel lifecycle: disabled, recovery window, normal operation
    typedef enum logic [1:0] {
        CH_DIS  = 2'd0,
        CH_WAIT = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;

    // One channel's set of quick-trip sources
    typedef struct packed {
        logic pwr_hi;
        logic pwr_lo;
        logic bias_hi;
        logic pwr_hx;
    } qt_set_t;

    // A source counts only when its own enable is set
    function automatic logic qt_hit(qt_set_t flag, qt_set_t en);
        return (flag.pwr_hi  & en.pwr_hi)  |
               (flag.pwr_lo  & en.pwr_lo)  |
               (flag.bias_hi & en.bias_hi) |
               (flag.pwr_hx  & en.pwr_hx);
    endfunction

endpackage

// File: rtl/lsf_qt_mask.sv
module lsf_qt_mask
    import lsf_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] qt_pwr_hi,
    input  logic [NCH-1:0] qt_pwr_lo,
    input  logic [NCH-1:0] qt_bias_hi,
    input  logic [NCH-1:0] qt_pwr_hx,
    input  logic [NCH-1:0] mask_pwr_hi,
    input  logic [NCH-1:0] mask_pwr_lo,
    input  logic [NCH-1:0] mask_bias_hi,
    input  logic [NCH-1:0] hx_enable,
    output logic [NCH-1:0] hit
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        qt_set_t flags, enables;

        always_comb begin
            flags   = '{pwr_hi: qt_pwr_hi[ch], pwr_lo: qt_pwr_lo[ch],
                        bias_hi: qt_bias_hi[ch], pwr_hx: qt_pwr_hx[ch]};
            enables = '{pwr_hi: mask_pwr_hi[ch], pwr_lo: mask_pwr_lo[ch],
                        bias_hi: mask_bias_hi[ch], pwr_hx: hx_enable[ch]};
            hit[ch] = qt_hit(flags, enables);
        end
    end

endmodule

// File: rtl/lsf_chan_ctrl.sv
module lsf_chan_ctrl
    import lsf_pkg::*;
#(
    parameter int WAIT_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic dis,
    input  logic hit,
    input  logic latch_mode,
    output logic fault,
    output logic shutdown
);

    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    ch_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic          fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_WAIT;
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else if (dis) begin
            state_q <= CH_DIS;
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                CH_DIS: begin
                    state_q <= CH_WAIT;
                    cnt_q   <= '0;
                    fault_q <= 1'b0;
                end
                CH_WAIT: begin
                    fault_q <= 1'b0;
                    if (cnt_q == LAST) begin
                        state_q <= CH_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                CH_RUN: begin
                    fault_q <= latch_mode ? (fault_q | hit) : hit;
                end
                default: begin
                    state_q <= CH_WAIT;
                    cnt_q   <= '0;
                    fault_q <= 1'b0;
                end
            endcase
        end
    end

    assign fault    = fault_q;
    assign shutdown = dis | (state_q != CH_RUN) | fault_q;

    // R6: a sampled disable clears the fault on the next edge
    a_r6_dis_clears: assert property (@(posedge clk) disable iff (rst)
        dis |=> !fault);

    // R7: releasing the disable keeps the driver off
    a_r7_release_holds: assert property (@(posedge clk) disable iff (rst)
        $fell(dis) |=> shutdown);

    // R7: window counter never passes its terminal count
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R3: non-latched fault follows the previous cycle's trip
    a_r3_follow: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_RUN && !latch_mode && !dis) |=> (fault == $past(hit)));

    // R4: latched fault holds without a disable
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (latch_mode && fault && !dis) |=> fault);

endmodule

// File: rtl/lsf_shutdown_ctrl.sv
module lsf_shutdown_ctrl
    import lsf_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int TICK_DIV    = 125000,
    parameter int RESET_TICKS = 130
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] qt_pwr_hi,
    input  logic [NCH-1:0] qt_pwr_lo,
    input  logic [NCH-1:0] qt_bias_hi,
    input  logic [NCH-1:0] qt_pwr_hx,
    input  logic [NCH-1:0] mask_pwr_hi,
    input  logic [NCH-1:0] mask_pwr_lo,
    input  logic [NCH-1:0] mask_bias_hi,
    input  logic [NCH-1:0] hx_enable,
    input  logic [NCH-1:0] txdis_pin,
    input  logic [NCH-1:0] sw_txdis,
    input  logic           latch_mode,
    output logic           fault_drive,
    output logic [NCH-1:0] shutdown,
    output logic [NCH-1:0] sts_txdis_pin,
    output logic [NCH-1:0] sts_sw_txdis,
    output logic           sts_fault
);

    localparam int WAIT_CYC = TICK_DIV * RESET_TICKS;

    logic [NCH-1:0] hit_w;
    logic [NCH-1:0] fault_w;
    logic [NCH-1:0] dis_w;

    assign dis_w = txdis_pin | sw_txdis;

    lsf_qt_mask #(.NCH(NCH)) u_mask (
        .qt_pwr_hi    (qt_pwr_hi),
        .qt_pwr_lo    (qt_pwr_lo),
        .qt_bias_hi   (qt_bias_hi),
        .qt_pwr_hx    (qt_pwr_hx),
        .mask_pwr_hi  (mask_pwr_hi),
        .mask_pwr_lo  (mask_pwr_lo),
        .mask_bias_hi (mask_bias_hi),
        .hx_enable    (hx_enable),
        .hit          (hit_w)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        lsf_chan_ctrl #(.WAIT_CYC(WAIT_CYC)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .dis        (dis_w[ch]),
            .hit        (hit_w[ch]),
            .latch_mode (latch_mode),
            .fault      (fault_w[ch]),
            .shutdown   (shutdown[ch])
        );
    end

    assign fault_drive   = |fault_w;
    assign sts_fault     = fault_drive;
    assign sts_txdis_pin = txdis_pin;
    assign sts_sw_txdis  = sw_txdis;

    // R1: the fault line only rises after an unmasked trip
    a_r1_rise_needs_hit: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_drive) |-> $past(|hit_w));

    // R10: the fault line is released on the edge after a reset
    a_r10_reset_release: assert property (@(posedge clk)
        rst |=> !fault_drive);

endmodule

// File: tb/lsf_shutdown_ctrl_bench.sv
module lsf_shutdown_ctrl_bench;

    localparam int NCH = 2;
    localparam int TD  = 4;
    localparam int RT  = 5;
    localparam int W   = TD * RT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] qt_pwr_hi = '0, qt_pwr_lo = '0, qt_bias_hi = '0, qt_pwr_hx = '0;
    logic [NCH-1:0] mask_pwr_hi = '0, mask_pwr_lo = '0, mask_bias_hi = '0, hx_enable = '0;
    logic [NCH-1:0] txdis_pin = '0, sw_txdis = '0;
    logic latch_mode = 1'b0;
    logic fault_drive, sts_fault;
    logic [NCH-1:0] shutdown, sts_txdis_pin, sts_sw_txdis;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lsf_shutdown_ctrl #(.NCH(NCH), .TICK_DIV(TD), .RESET_TICKS(RT)) u_lsf_shutdown_ctrl (
        .clk(clk), .rst(rst),
        .qt_pwr_hi(qt_pwr_hi), .qt_pwr_lo(qt_pwr_lo),
        .qt_bias_hi(qt_bias_hi), .qt_pwr_hx(qt_pwr_hx),
        .mask_pwr_hi(mask_pwr_hi), .mask_pwr_lo(mask_pwr_lo),
        .mask_bias_hi(mask_bias_hi), .hx_enable(hx_enable),
        .txdis_pin(txdis_pin), .sw_txdis(sw_txdis), .latch_mode(latch_mode),
        .fault_drive(fault_drive), .shutdown(shutdown),
        .sts_txdis_pin(sts_txdis_pin), .sts_sw_txdis(sts_sw_txdis),
        .sts_fault(sts_fault)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(3);
        chk("R10 reset fault", {7'd0, fault_drive}, 8'd0);
        chk("R10 reset shutdown", {6'd0, shutdown}, 8'd3);
        rst = 1'b0;
        tick(W - 1);
        chk("R10 window end-1", {6'd0, shutdown}, 8'd3);
        tick(1);
        chk("R10 window done", {6'd0, shutdown}, 8'd0);
    endtask

    task automatic t_mask();
        mask_pwr_hi = 2'b01;
        qt_bias_hi  = 2'b01;
        qt_pwr_lo   = 2'b10;
        tick(2);
        chk("R1 masked fault", {7'd0, fault_drive}, 8'd0);
        chk("R1 masked shutdown", {6'd0, shutdown}, 8'd0);
        qt_bias_hi = '0; qt_pwr_lo = '0;
        qt_pwr_hi  = 2'b01;
        tick(1);
        chk("R1 pwr_hi fault", {7'd0, fault_drive}, 8'd1);
        chk("R8 only ch0 down", {6'd0, shutdown}, 8'd1);
        chk("R9 sts fault", {7'd0, sts_fault}, 8'd1);
        qt_pwr_hi = '0;
        tick(1);
        chk("R3 clears", {7'd0, fault_drive}, 8'd0);
        chk("R3 shutdown off", {6'd0, shutdown}, 8'd0);
        mask_pwr_lo = 2'b10; qt_pwr_lo = 2'b10;
        tick(1);
        chk("R1 pwr_lo ch1", {6'd0, shutdown}, 8'd2);
        qt_pwr_lo = '0; mask_pwr_lo = '0;
        mask_bias_hi = 2'b01; qt_bias_hi = 2'b01;
        tick(1);
        chk("R1 bias ch0", {7'd0, fault_drive}, 8'd1);
        qt_bias_hi = '0;
        tick(1);
        chk("R3 bias gone", {7'd0, fault_drive}, 8'd0);
        mask_pwr_hi = '0; mask_bias_hi = '0;
    endtask

    task automatic t_hx();
        qt_pwr_hx = 2'b10;
        tick(2);
        chk("R2 hx disabled", {7'd0, fault_drive}, 8'd0);
        hx_enable = 2'b10;
        tick(1);
        chk("R2 hx enabled", {6'd0, shutdown}, 8'd2);
        qt_pwr_hx = '0; hx_enable = '0;
        tick(1);
        chk("R2 hx gone", {7'd0, fault_drive}, 8'd0);
    endtask

    task automatic t_latch();
        latch_mode = 1'b1;
        mask_bias_hi = 2'b01;
        qt_bias_hi = 2'b01;
        tick(1);
        qt_bias_hi = '0;
        tick(3);
        chk("R4 latched hold", {7'd0, fault_drive}, 8'd1);
        chk("R8 latched shutdown", {6'd0, shutdown}, 8'd1);
        sw_txdis = 2'b01;
        #1;
        chk("R5 sw immediate", {6'd0, shutdown}, 8'd1);
        chk("R9 sts sw", {6'd0, sts_sw_txdis}, 8'd1);
        tick(1);
        chk("R6 dis clears", {7'd0, fault_drive}, 8'd0);
        sw_txdis = '0;
        qt_bias_hi = 2'b01;
        tick(W);
        chk("R7 window held", {6'd0, shutdown}, 8'd1);
        chk("R7 trip ignored", {7'd0, fault_drive}, 8'd0);
        qt_bias_hi = '0;
        tick(1);
        chk("R7 resumed", {6'd0, shutdown}, 8'd0);
        chk("R7 no fault", {7'd0, fault_drive}, 8'd0);
        mask_bias_hi = '0;
    endtask

    task automatic t_collide();
        mask_pwr_hi = 2'b10;
        qt_pwr_hi = 2'b10;
        txdis_pin = 2'b10;
        #1;
        chk("R5 pin immediate", {6'd0, shutdown}, 8'd2);
        chk("R9 sts pin", {6'd0, sts_txdis_pin}, 8'd2);
        tick(1);
        chk("R6 clear wins", {7'd0, fault_drive}, 8'd0);
        qt_pwr_hi = '0; txdis_pin = '0;
        tick(W + 1);
        chk("R7 ch1 resumed", {6'd0, shutdown}, 8'd0);
        mask_pwr_hi = '0;
    endtask

    task automatic t_two_latched();
        mask_pwr_hi = 2'b11;
        qt_pwr_hi = 2'b11;
        tick(1);
        qt_pwr_hi = '0;
        tick(1);
        chk("R8 both latched", {6'd0, shutdown}, 8'd3);
        txdis_pin = 2'b01;
        tick(1);
        chk("R4 other ch holds", {7'd0, fault_drive}, 8'd1);
        sw_txdis = 2'b10;
        tick(1);
        chk("R4 all cleared", {7'd0, fault_drive}, 8'd0);
        txdis_pin = '0; sw_txdis = '0; mask_pwr_hi = '0;
        tick(W + 1);
        chk("R7 both resumed", {6'd0, shutdown}, 8'd0);
        latch_mode = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        tick(1);
        t_reset();
        t_mask();
        t_hx();
        t_latch();
        t_collide();
        t_two_latched();
        summary();
    end

endmodule